// File: doc/BRIEF.md
# CPU Debug Access Port

This block is a two-word bus slave that lets an external host watch and steer a small processor core. It sits on a pipelined Wishbone-style bus. Word 0 is the command/status word. A write to it picks one of 32 core registers and can also ask the core to halt, to run again, or to reset. A read of it returns the current selection and the core's run state. Word 1 is the data window. It reads or writes whichever register is currently picked, through a side port into the core's register file.

A read of any core register is always two bus operations: a command write that picks the register, then a data read. The supervisor and user program counters live at separate select codes, so fetching both takes four single accesses. The data window answers at once even while the core is running, so registers can be sampled without stopping the core. Writes through the window only take effect when the core reports that it is halted.

Top module: `dbg_port`

## Requirements
- R1: Every accepted request (cyc and stb high at a rising edge) is answered by ack high in the very next cycle, including back-to-back requests in consecutive cycles; ack is low in any cycle that does not follow an accepted request.
- R2: The stall output is low in every cycle, whether the core is halted or running.
- R3: A write to word 0 loads bits [4:0] into the register select; codes 0-15 are the supervisor set and 16-31 the user set. The select drives the register-file address output and is returned in bits [4:0] of the status word. The select does not change on any other access.
- R4: In a word 0 write, bit 8 sets the halt request and bit 9 clears it. When both bits are set, the halt request stays set.
- R5: A word 0 write with bit 10 set raises the core reset output for exactly one cycle, starting with the cycle of its ack. It also leaves the halt request set.
- R6: A read of word 0 returns a status word with these fields: [4:0] select, [8] halt request, [9] core halted, [10] core global-interrupt enable, [11] core sleep. All other bits are zero. The status bits are sampled in the request cycle, and the word carries no step or break-enable bits.
- R7: A read of word 1 returns the register-file word at the selected address, sampled in the request cycle. This holds whether the core is halted or running.
- R8: A write to word 1 drives the register-file write strobe with the bus data at the selected address during the request cycle, but only if the core reports halted in that cycle. Otherwise the write is acknowledged and has no effect.
- R9: After reset the halt request, core reset output, ack and register select are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wbCyc | input | 1 | Bus cycle active |
| wbStb | input | 1 | Request strobe |
| wbWe | input | 1 | Write enable |
| wbAddr | input | 1 | Word address: 0 command/status, 1 data |
| wbDataIn | input | 32 | Write data |
| wbAck | output | 1 | Acknowledge, one cycle after request |
| wbStall | output | 1 | Stall, held low |
| wbDataOut | output | 32 | Read data, valid with ack |
| cpuHalted | input | 1 | Core reports it is halted |
| cpuGie | input | 1 | Core global-interrupt enable |
| cpuSleep | input | 1 | Core sleep state |
| regRdData | input | 32 | Register-file read data at regAddr |
| haltReq | output | 1 | Request to halt the core |
| resetReq | output | 1 | One-cycle core reset pulse |
| regAddr | output | 5 | Register-file address (select) |
| regWrEn | output | 1 | Register-file write strobe |
| regWrData | output | 32 | Register-file write data |

## Verification
The hardest case to reach is a data write that arrives after the halt request has risen but before the core has reported halted. The write must be dropped, even though the host has already asked for a halt. The bench's core model follows the halt request one cycle late. The bench issues a data write in the cycle right after the halt command, so the write lands in that gap. A later read then shows that the register kept its old value. Back-to-back bursts that mix select changes, data reads and a write followed at once by a read check that each access sees the select and contents left by the one before it.

// File: rtl/dbg_port_pkg.sv
`timescale 1ns/1ps
package dbg_port_pkg;

  // command word control bits
  localparam int CMD_HALT_BIT  = 8;
  localparam int CMD_RUN_BIT   = 9;
  localparam int CMD_RESET_BIT = 10;

  // status word fields
  localparam int STAT_HREQ_BIT   = 8;
  localparam int STAT_HALTED_BIT = 9;
  localparam int STAT_GIE_BIT    = 10;
  localparam int STAT_SLEEP_BIT  = 11;

  // word addresses
  localparam logic ADDR_CMD  = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  // control to datapath strobes
  typedef struct packed {
    logic cmdWr;
    logic statRd;
    logic dataRd;
    logic dataWr;
  } dbgStrobes_t;

endpackage

// File: rtl/dbg_port_ctrl.sv
`timescale 1ns/1ps
module dbg_port_ctrl
  import dbg_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wbCyc,
  input  logic        wbStb,
  input  logic        wbWe,
  input  logic        wbAddr,
  input  logic        cpuHalted,
  output dbgStrobes_t strobes,
  output logic        wbAck,
  output logic        wbStall
);

  logic reqValid;

  assign reqValid = wbCyc && wbStb;

  always_comb begin
    strobes        = '0;
    strobes.cmdWr  = reqValid &&  wbWe && (wbAddr == ADDR_CMD);
    strobes.statRd = reqValid && !wbWe && (wbAddr == ADDR_CMD);
    strobes.dataRd = reqValid && !wbWe && (wbAddr == ADDR_DATA);
    strobes.dataWr = reqValid &&  wbWe && (wbAddr == ADDR_DATA) && cpuHalted;
  end

  // single-cycle answer, never back-pressure
  always_ff @(posedge clk) begin
    if (rst) wbAck <= 1'b0;
    else     wbAck <= reqValid;
  end

  assign wbStall = 1'b0;

  // R1: each accepted request answered next cycle
  a_r1_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb) |=> wbAck);

  // R1: no answer without a request
  a_r1_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
    !(wbCyc && wbStb) |=> !wbAck);

  // R8: a write strobe toward the core appears only from a data-word write
  a_r8_write_from_bus: assert property (@(posedge clk) disable iff (rst)
    strobes.dataWr |-> (wbWe && wbCyc));

endmodule

// File: rtl/dbg_port_dpath.sv
`timescale 1ns/1ps
module dbg_port_dpath
  import dbg_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  dbgStrobes_t       strobes,
  input  logic [DATA_W-1:0] wbDataIn,
  input  logic              cpuHalted,
  input  logic              cpuGie,
  input  logic              cpuSleep,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] wbDataOut,
  output logic [SEL_W-1:0]  regSel,
  output logic              haltReq,
  output logic              resetReq,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData
);

  logic [DATA_W-1:0] statusWord;

  always_comb begin
    statusWord                  = '0;
    statusWord[SEL_W-1:0]       = regSel;
    statusWord[STAT_HREQ_BIT]   = haltReq;
    statusWord[STAT_HALTED_BIT] = cpuHalted;
    statusWord[STAT_GIE_BIT]    = cpuGie;
    statusWord[STAT_SLEEP_BIT]  = cpuSleep;
  end

  // register-file side port acts in the request cycle
  assign regWrEn   = strobes.dataWr;
  assign regWrData = wbDataIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      regSel    <= '0;
      haltReq   <= 1'b0;
      resetReq  <= 1'b0;
      wbDataOut <= '0;
    end else begin
      resetReq <= 1'b0;
      if (strobes.cmdWr) begin
        regSel <= wbDataIn[SEL_W-1:0];
        if (wbDataIn[CMD_RESET_BIT]) begin
          resetReq <= 1'b1;
          haltReq  <= 1'b1;
        end else if (wbDataIn[CMD_HALT_BIT]) begin
          haltReq <= 1'b1;
        end else if (wbDataIn[CMD_RUN_BIT]) begin
          haltReq <= 1'b0;
        end
      end
      if (strobes.statRd)      wbDataOut <= statusWord;
      else if (strobes.dataRd) wbDataOut <= regRdData;
    end
  end

  // R5: reset request lasts one cycle
  a_r5_reset_single: assert property (@(posedge clk) disable iff (rst)
    resetReq |=> !resetReq);

  // R5: reset leaves the core halted
  a_r5_reset_halts: assert property (@(posedge clk) disable iff (rst)
    resetReq |-> haltReq);

  // R4: halt bit wins over run bit
  a_r4_halt_wins: assert property (@(posedge clk) disable iff (rst)
    (strobes.cmdWr && wbDataIn[CMD_HALT_BIT]) |=> haltReq);

  // R3: select moves only on a command write
  a_r3_sel_stable: assert property (@(posedge clk) disable iff (rst)
    !strobes.cmdWr |=> $stable(regSel));

endmodule

// File: rtl/dbg_port.sv
`timescale 1ns/1ps
module dbg_port
  import dbg_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic              wbAddr,
  input  logic [DATA_W-1:0] wbDataIn,
  output logic              wbAck,
  output logic              wbStall,
  output logic [DATA_W-1:0] wbDataOut,
  input  logic              cpuHalted,
  input  logic              cpuGie,
  input  logic              cpuSleep,
  input  logic [DATA_W-1:0] regRdData,
  output logic              haltReq,
  output logic              resetReq,
  output logic [SEL_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData
);

  dbgStrobes_t strobes;

  dbg_port_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .wbCyc     (wbCyc),
    .wbStb     (wbStb),
    .wbWe      (wbWe),
    .wbAddr    (wbAddr),
    .cpuHalted (cpuHalted),
    .strobes   (strobes),
    .wbAck     (wbAck),
    .wbStall   (wbStall)
  );

  dbg_port_dpath #(.DATA_W(DATA_W), .SEL_W(SEL_W)) dpath_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .wbDataIn  (wbDataIn),
    .cpuHalted (cpuHalted),
    .cpuGie    (cpuGie),
    .cpuSleep  (cpuSleep),
    .regRdData (regRdData),
    .wbDataOut (wbDataOut),
    .regSel    (regAddr),
    .haltReq   (haltReq),
    .resetReq  (resetReq),
    .regWrEn   (regWrEn),
    .regWrData (regWrData)
  );

  // R8: a register write is always answered
  a_r8_write_acked: assert property (@(posedge clk) disable iff (rst)
    regWrEn |=> wbAck);

endmodule

// File: tb/dbg_port_tb_top.sv
`timescale 1ns/1ps
module dbg_port_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wbCyc = 1'b0, wbStb = 1'b0, wbWe = 1'b0, wbAddr = 1'b0;
  logic [31:0] wbDataIn = '0;
  logic        wbAck, wbStall;
  logic [31:0] wbDataOut;
  logic        cpuHalted = 1'b0, cpuGie = 1'b1, cpuSleep = 1'b0;
  logic [31:0] regRdData;
  logic        haltReq, resetReq, regWrEn;
  logic [4:0]  regAddr;
  logic [31:0] regWrData;

  logic [31:0] coreRegs [32];

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  typedef struct packed { logic chk; logic [31:0] val; } expItem_t;
  expItem_t expQ[$];
  string    tagQ[$];

  always #2 clk = ~clk;

  dbg_port dut_i (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAddr(wbAddr), .wbDataIn(wbDataIn), .wbAck(wbAck), .wbStall(wbStall),
    .wbDataOut(wbDataOut), .cpuHalted(cpuHalted), .cpuGie(cpuGie),
    .cpuSleep(cpuSleep), .regRdData(regRdData), .haltReq(haltReq),
    .resetReq(resetReq), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData)
  );

  // core model: halts one cycle after request, register file side port
  assign regRdData = coreRegs[regAddr];
  always @(posedge clk) begin
    cpuHalted <= rst ? 1'b0 : haltReq;
    if (regWrEn) coreRegs[regAddr] <= regWrData;
  end

  function automatic logic [31:0] initVal(input int i);
    return 32'h1000_0000 + i * 32'h0000_0101;
  endfunction

  function automatic logic [31:0] stat(input int sel, input logic hreq,
      input logic halted, input logic gie, input logic slp);
    logic [31:0] w;
    w = '0;
    w[4:0] = sel[4:0];
    w[8] = hreq; w[9] = halted; w[10] = gie; w[11] = slp;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one request, returns at the falling edge where its ack shows
  task automatic req(input logic we, input logic a, input logic [31:0] d,
                     input logic chk, input logic [31:0] exp, input string tag);
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = we; wbAddr = a; wbDataIn = d;
    expQ.push_back({chk, exp});
    tagQ.push_back(tag);
    @(negedge clk);
    check(wbAck === 1'b1, "R1 ack next cycle", {31'd0, wbAck}, 32'd1);
    check(wbStall === 1'b0, "R2 stall low", {31'd0, wbStall}, 32'd0);
    wbCyc = 1'b0; wbStb = 1'b0; wbWe = 1'b0;
  endtask

  task automatic idle(input int n);
    wbCyc = 1'b0; wbStb = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard of answers
  always @(negedge clk) begin
    if (!rst && wbAck) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1 spurious ack", 32'd1, 32'd0);
      end else begin
        expItem_t it;
        string t;
        it = expQ.pop_front();
        t  = tagQ.pop_front();
        if (it.chk) check(wbDataOut === it.val, t, wbDataOut, it.val);
      end
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) coreRegs[i] = initVal(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check(haltReq === 1'b0, "R9 haltReq reset", {31'd0, haltReq}, 32'd0);
    check(resetReq === 1'b0, "R9 resetReq reset", {31'd0, resetReq}, 32'd0);
    check(wbAck === 1'b0, "R9 ack reset", {31'd0, wbAck}, 32'd0);
    check(regAddr === 5'd0, "R9 select reset", {27'd0, regAddr}, 32'd0);

    // R6 status while running
    req(1'b0, 1'b0, '0, 1'b1, stat(0, 0, 0, 1, 0), "R6 status running");
    idle(1);
    // R3 select then R7 read while running
    req(1'b1, 1'b0, 32'd3, 1'b0, '0, "R3 select 3");
    check(regAddr === 5'd3, "R3 address output", {27'd0, regAddr}, 32'd3);
    req(1'b0, 1'b1, '0, 1'b1, initVal(3), "R7 read reg 3 running");
    idle(1);
    // R3 both program counters in four back-to-back accesses
    req(1'b1, 1'b0, 32'd15, 1'b0, '0, "R3 select sup pc");
    req(1'b0, 1'b1, '0, 1'b1, initVal(15), "R3 sup pc read");
    req(1'b1, 1'b0, 32'd31, 1'b0, '0, "R3 select user pc");
    req(1'b0, 1'b1, '0, 1'b1, initVal(31), "R3 user pc read");
    idle(1);
    // R7 core updates a register while running
    coreRegs[31] = 32'hCAFE_0031;
    req(1'b0, 1'b1, '0, 1'b1, 32'hCAFE_0031, "R7 live sample");
    idle(1);
    // R8 write while running is ignored
    req(1'b1, 1'b1, 32'hDEAD_DEAD, 1'b0, '0, "R8 write running");
    idle(1);
    req(1'b0, 1'b1, '0, 1'b1, 32'hCAFE_0031, "R8 running write ignored");
    idle(1);
    // R4 halt, R8 write in the gap before core halts
    req(1'b1, 1'b0, 32'h0000_011F, 1'b0, '0, "R4 halt cmd");
    check(haltReq === 1'b1, "R4 halt set", {31'd0, haltReq}, 32'd1);
    req(1'b1, 1'b1, 32'hBAD0_BAD0, 1'b0, '0, "R8 write in halt gap");
    idle(2);
    req(1'b0, 1'b1, '0, 1'b1, 32'hCAFE_0031, "R8 gap write ignored");
    idle(1);
    // R6 status while halted, sleep set
    cpuGie = 1'b0; cpuSleep = 1'b1;
    req(1'b0, 1'b0, '0, 1'b1, stat(31, 1, 1, 0, 1), "R6 status halted");
    idle(1);
    // R8 write while halted then immediate read
    req(1'b1, 1'b1, 32'h1234_5678, 1'b0, '0, "R8 write halted");
    req(1'b0, 1'b1, '0, 1'b1, 32'h1234_5678, "R8 halted write taken");
    idle(1);
    // R4 both bits: halt stays
    req(1'b1, 1'b0, 32'h0000_0307, 1'b0, '0, "R4 halt and run");
    check(haltReq === 1'b1, "R4 halt wins", {31'd0, haltReq}, 32'd1);
    req(1'b0, 1'b1, '0, 1'b1, initVal(7), "R7 read reg 7 halted");
    idle(1);
    // R4 run alone
    req(1'b1, 1'b0, 32'h0000_0207, 1'b0, '0, "R4 run cmd");
    check(haltReq === 1'b0, "R4 run clears", {31'd0, haltReq}, 32'd0);
    idle(2);
    req(1'b0, 1'b0, '0, 1'b1, stat(7, 0, 0, 0, 1), "R6 status after run");
    idle(1);
    // R5 reset pulse
    req(1'b1, 1'b0, 32'h0000_0402, 1'b0, '0, "R5 reset cmd");
    check(resetReq === 1'b1, "R5 reset pulse high", {31'd0, resetReq}, 32'd1);
    check(haltReq === 1'b1, "R5 halted after reset", {31'd0, haltReq}, 32'd1);
    @(negedge clk);
    check(resetReq === 1'b0, "R5 reset pulse one cycle", {31'd0, resetReq}, 32'd0);
    idle(1);
    req(1'b0, 1'b0, '0, 1'b1, stat(2, 1, 1, 0, 1), "R5 status after reset");
    idle(1);
    // R1 burst mixing selects and reads
    req(1'b1, 1'b0, 32'd5, 1'b0, '0, "R1 burst sel 5");
    req(1'b0, 1'b1, '0, 1'b1, initVal(5), "R1 burst read 5");
    req(1'b1, 1'b0, 32'd6, 1'b0, '0, "R1 burst sel 6");
    req(1'b0, 1'b1, '0, 1'b1, initVal(6), "R1 burst read 6");
    req(1'b0, 1'b0, '0, 1'b1, stat(6, 1, 1, 0, 1), "R1 burst status");
    @(negedge clk);
    check(wbAck === 1'b0, "R1 no ack when idle", {31'd0, wbAck}, 32'd0);
    idle(2);
    check(expQ.size() == 0, "R1 all requests answered", expQ.size(), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule